// File: doc/BRIEF.md
# Turn-Message Receiver and Trigger Decoder

This block sits at the end of a timing distribution link, inside each instrument. Upstream logic hands it one sub-address/data byte pair at a time. Pairs whose address falls inside a 32-byte message are captured into a shadow buffer. Pairs with any other address are dropped. On each turn tick the shadow buffer is copied as a whole into a visible register file. The stable outputs and the host read port take their values from this visible file, so they never mix bytes from two turns.

The message has two classes of byte. The slow machine parameters (bytes 0 to 20) are kept until a later message overwrites them. The per-turn bytes (21 to 31) are wiped from the shadow buffer at every tick, so a command that the next message leaves out is not repeated. Each set bit of the trigger byte becomes a one-clock pulse on its own line. An interrupt flag is raised when the last byte of a message arrives, and the host clears it.

Top module: `turnMsgRx`

## Requirements
- R1: A pair with `byteValid` high and `byteAddr` from 0 to 31 writes the shadow byte at that address. A pair with an address of 32 or above changes no output, either at once or after later ticks.
- R2: Visible outputs change only in the clock after a cycle with `turnTick` high. At that point they take the shadow contents as they stood before that cycle's write. A byte written in the same cycle as a tick belongs to the next turn.
- R3: The slow fields are held across turns until they are overwritten. Multi-byte fields are big-endian: the lower address is the more significant byte. The mapping is: `machineMode` = byte 0, `beamType` = byte 1, `beamEnergy` = {2,3}, `bunchCurrent` = {4,5}, `bunchCount` = {6,7}, `nextBatch` = byte 8, `lastEvent` = {17,18}, `eventMask` = {19,20}.
- R4: `absTime` = {byte 9 .. byte 16}, with byte 9 in bits 63:56. All 64 bits change in the same clock.
- R5: For each bit i set in committed byte 21, `trigPulse[i]` is high for exactly one clock: the second clock edge after the tick, which is the cycle after the commit. At all other times it is low.
- R6: At each tick, shadow bytes 21 to 31 are cleared. A per-turn byte not re-sent in the next message is zero in the turn after that. A write in the tick cycle itself survives the clear.
- R7: `devCmd` = {byte 22 .. byte 31}, with byte 22 in bits 79:72. It holds the committed per-turn command bytes for one turn.
- R8: `irq` goes high the clock after a valid pair with address 31. It goes low the clock after `hostIrqClr`. If both happen in the same cycle, the set wins.
- R9: `hostRdData` returns the visible byte at `hostRdAddr` one clock after the address is applied. Reset clears all visible bytes, shadow bytes, `irq` and `trigPulse` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Qualifies the byte pair |
| byteAddr | input | 8 | Sub-address of the byte |
| byteData | input | 8 | Byte value |
| turnTick | input | 1 | One-cycle turn tick, commits the shadow buffer |
| hostIrqClr | input | 1 | Host clear of the end-of-message flag |
| hostRdAddr | input | 5 | Host read address into the visible file |
| hostRdData | output | 8 | Registered host read data |
| irq | output | 1 | End-of-message interrupt flag |
| machineMode | output | 8 | Committed byte 0 |
| beamType | output | 8 | Committed byte 1 |
| beamEnergy | output | 16 | Committed bytes 2-3 |
| bunchCurrent | output | 16 | Committed bytes 4-5 |
| bunchCount | output | 16 | Committed bytes 6-7 |
| nextBatch | output | 8 | Committed byte 8 |
| absTime | output | 64 | Committed bytes 9-16, atomic |
| lastEvent | output | 16 | Committed bytes 17-18 |
| eventMask | output | 16 | Committed bytes 19-20 |
| devCmd | output | 80 | Committed per-turn bytes 22-31 |
| trigPulse | output | 8 | One-clock trigger pulses from byte 21 |

## Verification
The assertions assume that `turnTick` is a single-cycle strobe and that all inputs are synchronous to `clk`. They do not assume that ticks are spaced apart, because back-to-back ticks are legal and the properties still hold. The stimulus sends directed messages and then a long pseudo-random phase. In that phase, ticks sometimes fall in consecutive cycles or coincide with a byte write or an interrupt clear. Addresses stray above 31 on purpose. Byte addresses are always driven to known values so that the range decode is never fed X.

// File: rtl/turnMsgPkg.sv
package turnMsgPkg;
  localparam int MSG_BYTES  = 32;
  localparam int IDX_W      = $clog2(MSG_BYTES);
  localparam int TURN_FIRST = 21;
  localparam int TRIG_IDX   = 21;
  localparam int DEV_FIRST  = 22;
  localparam int DEV_COUNT  = MSG_BYTES - DEV_FIRST;
  localparam int EOM_IDX    = MSG_BYTES - 1;
  localparam int TIME_FIRST = 9;
  localparam int TIME_BYTES = 8;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             commit;
    logic             clearTurn;
    logic             pulseArm;
  } ctrlStrobes_t;
endpackage

// File: rtl/turnMsgCtrl.sv
module turnMsgCtrl
  import turnMsgPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              turnTick,
  input  logic              hostIrqClr,
  output ctrlStrobes_t      strobes,
  output logic              irq
);
  logic inRange;
  logic eomSeen;
  logic tickQ;

  assign inRange = byteAddr < ADDR_W'(MSG_BYTES);
  assign eomSeen = byteValid && (byteAddr == ADDR_W'(EOM_IDX));

  always_comb begin
    strobes.wrEn      = byteValid && inRange;
    strobes.wrIdx     = byteAddr[IDX_W-1:0];
    strobes.commit    = turnTick;
    strobes.clearTurn = turnTick;
    strobes.pulseArm  = tickQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ <= 1'b0;
      irq   <= 1'b0;
    end else begin
      tickQ <= turnTick;
      if (eomSeen)         irq <= 1'b1;
      else if (hostIrqClr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/turnMsgData.sv
module turnMsgData
  import turnMsgPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [7:0]             byteData,
  input  logic [IDX_W-1:0]       hostRdAddr,
  output logic [7:0]             hostRdData,
  output logic [7:0]             machineMode,
  output logic [7:0]             beamType,
  output logic [15:0]            beamEnergy,
  output logic [15:0]            bunchCurrent,
  output logic [15:0]            bunchCount,
  output logic [7:0]             nextBatch,
  output logic [8*TIME_BYTES-1:0] absTime,
  output logic [15:0]            lastEvent,
  output logic [15:0]            eventMask,
  output logic [8*DEV_COUNT-1:0] devCmd,
  output logic [7:0]             trigPulse
);
  logic [7:0] shadowMem [MSG_BYTES];
  logic [7:0] visMem    [MSG_BYTES];

  // shadow buffer: a write wins over the per-turn clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_BYTES; i++) shadowMem[i] <= '0;
    end else begin
      for (int i = 0; i < MSG_BYTES; i++) begin
        if (strobes.wrEn && strobes.wrIdx == IDX_W'(i))
          shadowMem[i] <= byteData;
        else if (strobes.clearTurn && i >= TURN_FIRST)
          shadowMem[i] <= '0;
      end
    end
  end

  // visible file, copied whole on the tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_BYTES; i++) visMem[i] <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < MSG_BYTES; i++) visMem[i] <= shadowMem[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
      trigPulse  <= '0;
    end else begin
      hostRdData <= visMem[hostRdAddr];
      trigPulse  <= strobes.pulseArm ? visMem[TRIG_IDX] : 8'h00;
    end
  end

  assign machineMode  = visMem[0];
  assign beamType     = visMem[1];
  assign beamEnergy   = {visMem[2], visMem[3]};
  assign bunchCurrent = {visMem[4], visMem[5]};
  assign bunchCount   = {visMem[6], visMem[7]};
  assign nextBatch    = visMem[8];
  assign lastEvent    = {visMem[17], visMem[18]};
  assign eventMask    = {visMem[19], visMem[20]};

  for (genvar g = 0; g < TIME_BYTES; g++) begin : gTime
    assign absTime[8*(TIME_BYTES-g)-1 -: 8] = visMem[TIME_FIRST+g];
  end

  for (genvar g = 0; g < DEV_COUNT; g++) begin : gDev
    assign devCmd[8*(DEV_COUNT-g)-1 -: 8] = visMem[DEV_FIRST+g];
  end
endmodule

// File: rtl/turnMsgRx.sv
module turnMsgRx
  import turnMsgPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [7:0]        byteData,
  input  logic              turnTick,
  input  logic              hostIrqClr,
  input  logic [4:0]        hostRdAddr,
  output logic [7:0]        hostRdData,
  output logic              irq,
  output logic [7:0]        machineMode,
  output logic [7:0]        beamType,
  output logic [15:0]       beamEnergy,
  output logic [15:0]       bunchCurrent,
  output logic [15:0]       bunchCount,
  output logic [7:0]        nextBatch,
  output logic [63:0]       absTime,
  output logic [15:0]       lastEvent,
  output logic [15:0]       eventMask,
  output logic [79:0]       devCmd,
  output logic [7:0]        trigPulse
);
  ctrlStrobes_t strobes;

  turnMsgCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteAddr(byteAddr),
    .turnTick(turnTick), .hostIrqClr(hostIrqClr), .strobes(strobes), .irq(irq)
  );

  turnMsgData uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .machineMode(machineMode), .beamType(beamType), .beamEnergy(beamEnergy),
    .bunchCurrent(bunchCurrent), .bunchCount(bunchCount), .nextBatch(nextBatch),
    .absTime(absTime), .lastEvent(lastEvent), .eventMask(eventMask),
    .devCmd(devCmd), .trigPulse(trigPulse)
  );
endmodule

// File: rtl/turnMsgChk.sv
module turnMsgChk (
  input logic        clk,
  input logic        rstN,
  input logic        byteValid,
  input logic [7:0]  byteAddr,
  input logic        turnTick,
  input logic        hostIrqClr,
  input logic        irq,
  input logic [7:0]  machineMode,
  input logic [63:0] absTime,
  input logic [15:0] eventMask,
  input logic [79:0] devCmd,
  input logic [7:0]  trigPulse
);
  // R2
  stable_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !turnTick |=> $stable({machineMode, absTime, eventMask, devCmd}));

  // R5
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse != 8'h00) |-> $past(turnTick, 2));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteAddr == 8'd31) |=> irq);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(hostIrqClr));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(byteValid && byteAddr == 8'd31));
endmodule

bind turnMsgRx turnMsgChk chk (.*);

// File: tb/turnMsgRx_test.sv
`timescale 1ns/1ps
module turnMsgRx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteAddr = '0;
  logic [7:0] byteData = '0;
  logic turnTick = 1'b0;
  logic hostIrqClr = 1'b0;
  logic [4:0] hostRdAddr = '0;
  logic [7:0] hostRdData, machineMode, beamType, nextBatch, trigPulse;
  logic irq;
  logic [15:0] beamEnergy, bunchCurrent, bunchCount, lastEvent, eventMask;
  logic [63:0] absTime;
  logic [79:0] devCmd;

  always #2.5 clk = ~clk;

  turnMsgRx uut (.*);

  // behavioural reference
  int refSh [32];
  int refVis [32];
  int refRd, refTrig, refIrq, refTickQ;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < 32; i++) begin refSh[i] = 0; refVis[i] = 0; end
    refRd = 0; refTrig = 0; refIrq = 0; refTickQ = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin refSh[i] = 0; refVis[i] = 0; end
      refRd = 0; refTrig = 0; refIrq = 0; refTickQ = 0;
    end else begin
      int nRd, nTrig;
      nRd = refVis[hostRdAddr];
      nTrig = refTickQ ? refVis[21] : 0;
      if (turnTick) begin
        for (int i = 0; i < 32; i++) refVis[i] = refSh[i];
        for (int i = 21; i < 32; i++) refSh[i] = 0;
      end
      if (byteValid && byteAddr < 32) refSh[byteAddr] = byteData;
      if (byteValid && byteAddr == 31) refIrq = 1;
      else if (hostIrqClr) refIrq = 0;
      refTickQ = turnTick;
      refRd = nRd;
      refTrig = nTrig;
    end
  end

  task automatic check(string req, string name, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, name, act, exp, $time);
    end
  endtask

  function automatic logic [79:0] cat(int first, int n);
    logic [79:0] v = '0;
    for (int k = 0; k < n; k++) v = (v << 8) | 80'(refVis[first+k] & 8'hFF);
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("R3", "machineMode", 80'(machineMode), cat(0, 1));
      check("R3", "beamType", 80'(beamType), cat(1, 1));
      check("R3", "beamEnergy", 80'(beamEnergy), cat(2, 2));
      check("R3", "bunchCurrent", 80'(bunchCurrent), cat(4, 2));
      check("R3", "bunchCount", 80'(bunchCount), cat(6, 2));
      check("R3", "nextBatch", 80'(nextBatch), cat(8, 1));
      check("R4", "absTime", 80'(absTime), cat(9, 8));
      check("R3", "lastEvent", 80'(lastEvent), cat(17, 2));
      check("R3", "eventMask", 80'(eventMask), cat(19, 2));
      check("R7", "devCmd", devCmd, cat(22, 10));
      check("R5", "trigPulse", 80'(trigPulse), 80'(refTrig));
      check("R8", "irq", 80'(irq), 80'(refIrq));
      check("R9", "hostRdData", 80'(hostRdData), 80'(refRd));
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        finish();
      end
    end
  end

  task automatic finish();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive(bit v, int a, int d, bit t, bit c);
    @(negedge clk);
    byteValid = v; byteAddr = 8'(a); byteData = 8'(d);
    turnTick = t; hostIrqClr = c;
    hostRdAddr = 5'(hostRdAddr + 1);
  endtask

  task automatic sendMsg(int seed, int lastAddr);
    for (int a = 0; a <= lastAddr; a++) drive(1, a, (a * 37 + seed) & 255, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: full message, then an out-of-range write that must not appear
    sendMsg(5, 31);
    drive(1, 40, 8'hAA, 0, 0);
    drive(1, 200, 8'h55, 0, 0);
    drive(0, 0, 0, 1, 0);          // R2: commit
    repeat (4) drive(0, 0, 0, 0, 0);
    // R6: next message omits per-turn bytes, triggers must not repeat
    sendMsg(9, 20);
    drive(0, 0, 0, 1, 1);          // R8: host clear with tick
    repeat (4) drive(0, 0, 0, 0, 0);
    // R2/R6: write in tick cycle goes to next turn and survives clear
    drive(1, 21, 8'hC3, 1, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 1, 0);          // back-to-back ticks, R5
    repeat (3) drive(0, 0, 0, 0, 0);
    // R8: set and clear in same cycle, set wins
    drive(1, 31, 8'h11, 0, 1);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      int a = (r < 5) ? int'($urandom % 256) : int'($urandom % 34);
      drive(r < 60, a, int'($urandom % 256), ($urandom % 30) == 0, ($urandom % 20) == 0);
    end
    repeat (4) drive(0, 0, 0, 0, 0);
    finish();
  end
endmodule